// File: doc/BRIEF.md
# Speculation-Tagged Direct-Mapped Data Cache

This block is a small direct-mapped data cache for a core that issues loads before it knows whether they are on the correct path. Each load carries a speculation identifier and a flag saying whether it is still unconfirmed. When such a load misses, the refilled line is marked as speculative and tagged with the identifier of the load that caused it. The core can hit that line freely. Any observer outside the core, using the snoop/read port, sees the line as absent until the speculation resolves.

Resolution arrives on two single-cycle pulse ports. A commit names one identifier, and every line tagged with it becomes an ordinary visible line. A squash names one identifier, and every line filled under it is dropped. A refill still in flight follows the same rules, so a line whose speculation is squashed before it lands is never installed as valid. Refills come from an external memory as four consecutive word beats.

Top module: `spec_tag_cache`

## Requirements
- R1: After reset no line is valid and none is speculative: a snoop misses, the first core load to any address misses, and `ldBusy` and `specErr` are low.
- R2: A word address splits into offset `ldAddr[1:0]`, line index `ldAddr[5:2]` and tag `ldAddr[11:6]`. Two addresses with equal index and different tag share one line, and a fill of one evicts the other.
- R3: A core load is accepted on a clock edge where `ldReq` is high and `ldBusy` is low. On a miss, `memReq` is high for exactly the next cycle with `memAddr` holding the line-aligned address (offset bits zero). The cache then takes four `memValid` beats, beat k being word k of the line. `ldResp` is high for the one cycle after the fourth beat, and `ldBusy` is high from the cycle after acceptance through the `ldResp` cycle.
- R4: On a core load hit, `ldResp` is high in the cycle after acceptance with the addressed word on `ldRdata`, and no `memReq` is issued.
- R5: A refill caused by a load with `ldSpec`=1 stores a speculative flag and the load's `ldId`. A snoop of a valid speculative line reports `snpHit`=0. A line refilled with `ldSpec`=0 is visible to snoops from the `ldResp` cycle onwards.
- R6: A commit pulse (`cmtValid`=1, `cmtId`) clears the speculative flag of every line tagged with that identifier. From the next cycle those lines hit on a snoop. Lines tagged with other identifiers are unchanged.
- R7: A squash pulse (`sqValid`=1, `sqId`) invalidates every speculative line tagged with that identifier, so later core loads to it miss and a later commit of that identifier does not bring it back. Non-speculative lines are untouched.
- R8: A core load that hits a speculative line filled under another identifier returns the data and leaves the line's flag and identifier unchanged. Committing the hitting load's identifier does not reveal the line.
- R9: A commit or squash of the identifier of a refill in flight, including one that arrives on the installing edge, applies to that refill. After a commit the line is installed visible. After a squash the line is installed invalid, and the load still receives its data.
- R10: A commit and a squash of the same identifier in the same cycle is illegal. `specErr` is then high for exactly the following cycle, the squash takes effect and the commit is discarded. A commit and a squash of different identifiers in one cycle both take effect without error.
- R11: When `snpHit` is high, `snpData` carries the word at `snpAddr`. `snpHit` is high only when `snpReq` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ldReq | input | 1 | Core load request |
| ldAddr | input | 12 | Core load word address |
| ldSpec | input | 1 | Load is unconfirmed |
| ldId | input | 3 | Speculation identifier of the load |
| ldBusy | output | 1 | A load is being processed; new requests wait |
| ldResp | output | 1 | Load data valid this cycle |
| ldRdata | output | 32 | Load data |
| memReq | output | 1 | Refill request pulse |
| memAddr | output | 12 | Line-aligned refill address |
| memValid | input | 1 | Refill beat valid |
| memData | input | 32 | Refill beat data |
| cmtValid | input | 1 | Commit pulse |
| cmtId | input | 3 | Identifier being committed |
| sqValid | input | 1 | Squash pulse |
| sqId | input | 3 | Identifier being squashed |
| snpReq | input | 1 | External read/snoop request |
| snpAddr | input | 12 | Snoop word address |
| snpHit | output | 1 | Snoop found a visible line |
| snpData | output | 32 | Snooped word |
| specErr | output | 1 | Illegal same-identifier commit and squash seen last cycle |

## Verification
The bench targets the points where a speculative fill meets its resolution. These are a squash or commit that arrives during a refill or on the installing edge itself: a design that ignores it would leak a squashed line or hide a committed one. It also covers a commit of the wrong identifier, which would reveal a line to a snoop early, and a core hit from another identifier, which a careless design would re-tag and so commit or squash with the wrong owner. It drives the same-identifier commit/squash collision, where letting the commit win would expose mis-speculated data. It also evicts between two tags sharing one index, which a wrong index slice would turn into a false hit or a lost line.

// File: rtl/stc_pkg.sv
package stc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MREQ,
    ST_FILL,
    ST_RESP
  } stcState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchReq;     // capture load request fields
    logic captureBeat;  // store a refill beat in the fill buffer
    logic install;      // write the completed line into the arrays
  } stcStrobes_t;

endpackage

// File: rtl/stc_ctrl.sv
module stc_ctrl
  import stc_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int OFF_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ldReq,
  input  logic             lookupHit,
  input  logic             memValid,
  output stcStrobes_t      strobes,
  output logic [OFF_W-1:0] beatIdx,
  output logic             ldBusy,
  output logic             ldResp,
  output logic             memReq
);

  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

  stcState_t        state, stateNext;
  logic [OFF_W-1:0] beatCnt;
  logic             accept;
  logic             captureNow;
  logic             lastBeat;

  assign accept     = (state == ST_IDLE) && ldReq;
  assign captureNow = (state == ST_FILL) && memValid;
  assign lastBeat   = (beatCnt == LAST_BEAT);

  always_comb begin
    strobes             = '0;
    strobes.latchReq    = accept;
    strobes.captureBeat = captureNow;
    strobes.install     = captureNow && lastBeat;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (accept) stateNext = lookupHit ? ST_RESP : ST_MREQ;
      ST_MREQ: stateNext = ST_FILL;
      ST_FILL: if (captureNow && lastBeat) stateNext = ST_RESP;
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_MREQ)  beatCnt <= '0;
      else if (captureNow)   beatCnt <= beatCnt + 1'b1;
    end
  end

  assign beatIdx = beatCnt;
  assign ldBusy  = (state != ST_IDLE);
  assign ldResp  = (state == ST_RESP);
  assign memReq  = (state == ST_MREQ);

endmodule

// File: rtl/stc_datapath.sv
module stc_datapath
  import stc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int ID_W   = 3,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int OFF_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  stcStrobes_t       strobes,
  input  logic [OFF_W-1:0]  beatIdx,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic              ldSpec,
  input  logic [ID_W-1:0]   ldId,
  input  logic [DATA_W-1:0] memData,
  input  logic              cmtValid,
  input  logic [ID_W-1:0]   cmtId,
  input  logic              sqValid,
  input  logic [ID_W-1:0]   sqId,
  input  logic              snpReq,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              lookupHit,
  output logic [DATA_W-1:0] ldRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              snpHit,
  output logic [DATA_W-1:0] snpData,
  output logic              specErr
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  // Line state
  logic [LINES-1:0]  lineValid;
  logic [LINES-1:0]  lineSpec;
  logic [ID_W-1:0]   lineId   [LINES];
  logic [TAG_W-1:0]  lineTag  [LINES];
  logic [DATA_W-1:0] lineData [LINES][WORDS];
  logic [DATA_W-1:0] fillBuf  [WORDS];

  // Latched request
  logic [ADDR_W-1:0] reqAddr;
  logic              reqSpec;
  logic              reqKill;
  logic [ID_W-1:0]   reqId;

  logic [IDX_W-1:0] ldIdx, reqIdx, snpIdx;
  logic [TAG_W-1:0] ldTag, reqTag, snpTag;
  logic [OFF_W-1:0] reqOff, snpOff;

  assign ldIdx  = ldAddr[OFF_W +: IDX_W];
  assign ldTag  = ldAddr[ADDR_W-1 -: TAG_W];
  assign reqIdx = reqAddr[OFF_W +: IDX_W];
  assign reqTag = reqAddr[ADDR_W-1 -: TAG_W];
  assign reqOff = reqAddr[OFF_W-1:0];
  assign snpIdx = snpAddr[OFF_W +: IDX_W];
  assign snpTag = snpAddr[ADDR_W-1 -: TAG_W];
  assign snpOff = snpAddr[OFF_W-1:0];

  // Resolution decode: a same-ID collision keeps the squash only
  logic collide, cmtEff, sqHitPend, cmtHitPend;
  logic installValid, installSpec;
  logic [LINES-1:0] sqMatch, cmtMatch;

  assign collide    = cmtValid && sqValid && (cmtId == sqId);
  assign cmtEff     = cmtValid && !collide;
  assign sqHitPend  = sqValid && reqSpec && (reqId == sqId);
  assign cmtHitPend = cmtEff && reqSpec && (reqId == cmtId);

  assign installValid = !(reqKill || sqHitPend);
  assign installSpec  = reqSpec && !cmtHitPend && installValid;

  for (genvar i = 0; i < LINES; i++) begin : g_lineMatch
    assign sqMatch[i]  = sqValid && lineSpec[i] && (lineId[i] == sqId);
    assign cmtMatch[i] = cmtEff && lineSpec[i] && (lineId[i] == cmtId);
  end

  // Flag state with reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineValid <= '0;
      lineSpec  <= '0;
    end else begin
      lineValid <= lineValid & ~sqMatch;
      lineSpec  <= lineSpec & ~(sqMatch | cmtMatch);
      if (strobes.install) begin
        lineValid[reqIdx] <= installValid;
        lineSpec[reqIdx]  <= installSpec;
      end
    end
  end

  // Payload state without reset
  always_ff @(posedge clk) begin
    if (strobes.captureBeat) fillBuf[beatIdx] <= memData;
    if (strobes.install) begin
      lineId[reqIdx]  <= reqId;
      lineTag[reqIdx] <= reqTag;
      for (int w = 0; w < WORDS; w++) begin
        lineData[reqIdx][w] <= (w == WORDS - 1) ? memData : fillBuf[w];
      end
    end
  end

  // Pending request, tracking resolutions while the refill runs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddr <= '0;
      reqSpec <= 1'b0;
      reqKill <= 1'b0;
      reqId   <= '0;
      specErr <= 1'b0;
    end else begin
      specErr <= collide;
      if (strobes.latchReq) begin
        reqAddr <= ldAddr;
        reqSpec <= ldSpec;
        reqId   <= ldId;
        reqKill <= 1'b0;
      end else begin
        if (cmtHitPend) reqSpec <= 1'b0;
        if (sqHitPend)  reqKill <= 1'b1;
      end
    end
  end

  assign lookupHit = lineValid[ldIdx] && (lineTag[ldIdx] == ldTag);
  assign ldRdata   = lineData[reqIdx][reqOff];
  assign memAddr   = {reqTag, reqIdx, {OFF_W{1'b0}}};
  assign snpHit    = snpReq && lineValid[snpIdx] && !lineSpec[snpIdx]
                     && (lineTag[snpIdx] == snpTag);
  assign snpData   = lineData[snpIdx][snpOff];

endmodule

// File: rtl/spec_tag_cache.sv
module spec_tag_cache
  import stc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int ID_W   = 3,
  parameter int LINES  = 16,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldReq,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic              ldSpec,
  input  logic [ID_W-1:0]   ldId,
  output logic              ldBusy,
  output logic              ldResp,
  output logic [DATA_W-1:0] ldRdata,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [DATA_W-1:0] memData,
  input  logic              cmtValid,
  input  logic [ID_W-1:0]   cmtId,
  input  logic              sqValid,
  input  logic [ID_W-1:0]   sqId,
  input  logic              snpReq,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpHit,
  output logic [DATA_W-1:0] snpData,
  output logic              specErr
);

  localparam int OFF_W = $clog2(WORDS);

  stcStrobes_t      strobes;
  logic [OFF_W-1:0] beatIdx;
  logic             lookupHit;

  stc_ctrl #(.WORDS(WORDS), .OFF_W(OFF_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ldReq     (ldReq),
    .lookupHit (lookupHit),
    .memValid  (memValid),
    .strobes   (strobes),
    .beatIdx   (beatIdx),
    .ldBusy    (ldBusy),
    .ldResp    (ldResp),
    .memReq    (memReq)
  );

  stc_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W),
    .LINES(LINES), .WORDS(WORDS), .OFF_W(OFF_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .beatIdx   (beatIdx),
    .ldAddr    (ldAddr),
    .ldSpec    (ldSpec),
    .ldId      (ldId),
    .memData   (memData),
    .cmtValid  (cmtValid),
    .cmtId     (cmtId),
    .sqValid   (sqValid),
    .sqId      (sqId),
    .snpReq    (snpReq),
    .snpAddr   (snpAddr),
    .lookupHit (lookupHit),
    .ldRdata   (ldRdata),
    .memAddr   (memAddr),
    .snpHit    (snpHit),
    .snpData   (snpData),
    .specErr   (specErr)
  );

endmodule

// File: rtl/spec_tag_cache_chk.sv
module spec_tag_cache_chk #(
  parameter int ID_W  = 3,
  parameter int OFF_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             ldBusy,
  input logic             ldResp,
  input logic             memReq,
  input logic [OFF_W-1:0] memAddrOff,
  input logic             cmtValid,
  input logic [ID_W-1:0]  cmtId,
  input logic             sqValid,
  input logic [ID_W-1:0]  sqId,
  input logic             snpReq,
  input logic             snpHit,
  input logic             specErr
);

  a_r3_memreq_single: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  a_r3_memreq_busy: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> ldBusy);

  a_r3_memreq_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddrOff == '0));

  a_r3_resp_then_idle: assert property (@(posedge clk) disable iff (!rstN)
    ldResp |=> !ldBusy);

  a_r4_resp_busy: assert property (@(posedge clk) disable iff (!rstN)
    ldResp |-> (ldBusy && !memReq));

  a_r10_err_raised: assert property (@(posedge clk) disable iff (!rstN)
    (cmtValid && sqValid && (cmtId == sqId)) |=> specErr);

  a_r10_err_cause: assert property (@(posedge clk) disable iff (!rstN)
    specErr |-> $past(cmtValid && sqValid && (cmtId == sqId)));

  a_r11_snoop_gated: assert property (@(posedge clk) disable iff (!rstN)
    snpHit |-> snpReq);

endmodule

bind spec_tag_cache spec_tag_cache_chk #(.ID_W(ID_W), .OFF_W(OFF_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ldBusy     (ldBusy),
  .ldResp     (ldResp),
  .memReq     (memReq),
  .memAddrOff (memAddr[OFF_W-1:0]),
  .cmtValid   (cmtValid),
  .cmtId      (cmtId),
  .sqValid    (sqValid),
  .sqId       (sqId),
  .snpReq     (snpReq),
  .snpHit     (snpHit),
  .specErr    (specErr)
);

// File: tb/test_spec_tag_cache.sv
module test_spec_tag_cache;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldReq = 1'b0;
  logic [11:0] ldAddr = '0;
  logic        ldSpec = 1'b0;
  logic [2:0]  ldId = '0;
  logic        ldBusy, ldResp, memReq, snpHit, specErr;
  logic [31:0] ldRdata, snpData;
  logic [11:0] memAddr;
  logic        memValid = 1'b0;
  logic [31:0] memData = '0;
  logic        cmtValid = 1'b0;
  logic [2:0]  cmtId = '0;
  logic        sqValid = 1'b0;
  logic [2:0]  sqId = '0;
  logic        snpReq = 1'b0;
  logic [11:0] snpAddr = '0;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  spec_tag_cache i_spec_tag_cache (
    .clk(clk), .rstN(rstN), .ldReq(ldReq), .ldAddr(ldAddr), .ldSpec(ldSpec),
    .ldId(ldId), .ldBusy(ldBusy), .ldResp(ldResp), .ldRdata(ldRdata),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .cmtValid(cmtValid), .cmtId(cmtId), .sqValid(sqValid), .sqId(sqId),
    .snpReq(snpReq), .snpAddr(snpAddr), .snpHit(snpHit), .snpData(snpData),
    .specErr(specErr)
  );

  function automatic logic [31:0] memWord(input logic [11:0] a);
    return {8'h5A, 4'h0, a, 8'hC3};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural memory: four beats after seeing a request
  initial begin
    logic [11:0] base;
    forever begin
      @(negedge clk);
      if (rstN && memReq) begin
        base = memAddr;
        for (int b = 0; b < 4; b++) begin
          @(negedge clk);
          memValid = 1'b1;
          memData  = memWord(base + 12'(b));
        end
        @(negedge clk);
        memValid = 1'b0;
      end
    end
  end

  // Reference model, compared every cycle just before the rising edge
  int          phase = 0;  // 0 idle, 1 request, 2 filling, 3 respond
  int          beats = 0;
  logic [11:0] rAddr = '0;
  bit          rSpec = 0, rKill = 0, errQ = 0;
  logic [2:0]  rId = '0;
  bit          mV [16];
  bit          mS [16];
  logic [2:0]  mI [16];
  logic [5:0]  mT [16];

  always @(negedge clk) begin
    #8;
    if (!rstN) begin
      phase = 0; beats = 0; rSpec = 0; rKill = 0; errQ = 0;
      for (int i = 0; i < 16; i++) begin mV[i] = 0; mS[i] = 0; end
    end else begin
      bit expSnp, hit, collide, cmtE, sqP, cmP, inst;
      int si, li, ri;
      si = int'(snpAddr[5:2]);
      expSnp = snpReq && mV[si] && !mS[si] && (mT[si] == snpAddr[11:6]);
      check("R3 ldBusy", 32'(ldBusy), 32'(phase != 0));
      check("R3 memReq", 32'(memReq), 32'(phase == 1));
      if (phase == 1) check("R3 memAddr", 32'(memAddr), 32'({rAddr[11:2], 2'b00}));
      check("R4 ldResp", 32'(ldResp), 32'(phase == 3));
      if (phase == 3) check("R4 ldRdata", ldRdata, memWord(rAddr));
      check("R5 snpHit", 32'(snpHit), 32'(expSnp));
      if (expSnp) check("R11 snpData", snpData, memWord(snpAddr));
      check("R10 specErr", 32'(specErr), 32'(errQ));

      // advance by one clock with current inputs
      li = int'(ldAddr[5:2]);
      ri = int'(rAddr[5:2]);
      hit = mV[li] && (mT[li] == ldAddr[11:6]);
      collide = cmtValid && sqValid && (cmtId == sqId);
      cmtE = cmtValid && !collide;
      sqP = sqValid && rSpec && (rId == sqId);
      cmP = cmtE && rSpec && (rId == cmtId);
      inst = (phase == 2) && memValid && (beats == 3);
      errQ = collide;
      for (int i = 0; i < 16; i++) begin
        if (sqValid && mS[i] && mI[i] == sqId) begin mV[i] = 0; mS[i] = 0; end
        else if (cmtE && mS[i] && mI[i] == cmtId) mS[i] = 0;
      end
      if (inst) begin
        mV[ri] = !(rKill || sqP);
        mS[ri] = rSpec && !cmP && mV[ri];
        mI[ri] = rId;
        mT[ri] = rAddr[11:6];
      end
      case (phase)
        0: if (ldReq) begin
             rAddr = ldAddr; rSpec = ldSpec; rId = ldId; rKill = 0;
             phase = hit ? 3 : 1;
           end
        1: begin phase = 2; beats = 0; end
        2: if (memValid) begin
             if (beats == 3) phase = 3; else beats++;
           end
        default: phase = 0;
      endcase
      if (!(phase != 0 && ldReq && rAddr == ldAddr && beats == 0 && 0)) begin
        if (cmP) rSpec = 0;
        if (sqP) rKill = 1;
      end
    end
  end

  // Stimulus tasks; each begins on a falling edge
  task automatic loadExpect(input logic [11:0] a, input bit spec, input logic [2:0] id,
                            input bit expMiss, input string req);
    bit sawReq;
    @(negedge clk);
    ldReq = 1'b1; ldAddr = a; ldSpec = spec; ldId = id;
    @(negedge clk);
    ldReq = 1'b0;
    sawReq = 0;
    while (ldBusy) begin
      if (memReq) sawReq = 1;
      @(negedge clk);
    end
    check(req, 32'(sawReq), 32'(expMiss));
  endtask

  task automatic loadResolve(input logic [11:0] a, input logic [2:0] id, input int delay,
                             input bit doCommit);
    @(negedge clk);
    ldReq = 1'b1; ldAddr = a; ldSpec = 1'b1; ldId = id;
    @(negedge clk);
    ldReq = 1'b0;
    repeat (delay - 1) @(negedge clk);
    if (doCommit) begin cmtValid = 1'b1; cmtId = id; end
    else begin sqValid = 1'b1; sqId = id; end
    @(negedge clk);
    cmtValid = 1'b0; sqValid = 1'b0;
    while (ldBusy) @(negedge clk);
  endtask

  task automatic pulse(input bit c, input logic [2:0] cid, input bit s,
                       input logic [2:0] sid, input bit expErr, input string req);
    @(negedge clk);
    cmtValid = c; cmtId = cid; sqValid = s; sqId = sid;
    @(negedge clk);
    cmtValid = 1'b0; sqValid = 1'b0;
    check(req, 32'(specErr), 32'(expErr));
  endtask

  task automatic snoopCheck(input logic [11:0] a, input bit expHit, input string req);
    @(negedge clk);
    snpReq = 1'b1; snpAddr = a;
    #8;
    check(req, 32'(snpHit), 32'(expHit));
    if (expHit) check(req, snpData, memWord(a));
    @(negedge clk);
    snpReq = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #8;
    check("R1 ldBusy after reset", 32'(ldBusy), 32'd0);
    check("R1 specErr after reset", 32'(specErr), 32'd0);
    snoopCheck(12'h010, 0, "R1 snoop after reset");
    snoopCheck(12'h3FF, 0, "R1 snoop after reset");

    // non-speculative fill and hit
    loadExpect(12'h012, 0, 3'd0, 1, "R1 first load misses");
    snoopCheck(12'h011, 1, "R5 plain fill visible");
    loadExpect(12'h013, 0, 3'd0, 0, "R4 hit no refill");

    // speculative fill at same index evicts
    loadExpect(12'h050, 1, 3'd2, 1, "R2 same index other tag misses");
    snoopCheck(12'h010, 0, "R2 old tag evicted");
    snoopCheck(12'h050, 0, "R5 speculative line hidden");
    loadExpect(12'h053, 0, 3'd5, 0, "R8 core hits other-ID line");
    pulse(1, 3'd5, 0, 3'd0, 0, "R6 commit no error");
    snoopCheck(12'h052, 0, "R8 line keeps its own ID");
    pulse(1, 3'd2, 0, 3'd0, 0, "R6 commit no error");
    snoopCheck(12'h052, 1, "R6 committed line visible");

    // squash versus commit on separate lines
    loadExpect(12'h023, 1, 3'd3, 1, "R3 spec miss");
    loadExpect(12'h004, 1, 3'd4, 1, "R2 distinct index miss");
    pulse(0, 3'd0, 1, 3'd3, 0, "R7 squash no error");
    pulse(1, 3'd3, 0, 3'd0, 0, "R7 late commit no error");
    pulse(1, 3'd4, 0, 3'd0, 0, "R6 commit no error");
    snoopCheck(12'h006, 1, "R6 commit reveals line");
    snoopCheck(12'h023, 0, "R7 squashed line stays gone");
    snoopCheck(12'h052, 1, "R7 plain line untouched");
    loadExpect(12'h020, 0, 3'd0, 1, "R7 squashed line misses");

    // resolution during refill
    loadResolve(12'h0C9, 3'd6, 2, 1);
    snoopCheck(12'h0C9, 1, "R9 commit mid-fill");
    loadResolve(12'h0F1, 3'd1, 2, 0);
    snoopCheck(12'h0F1, 0, "R9 squash mid-fill");
    loadExpect(12'h0F0, 0, 3'd0, 1, "R9 squashed fill not installed");
    loadResolve(12'h1B4, 3'd7, 5, 1);
    snoopCheck(12'h1B7, 1, "R9 commit on install edge");
    loadResolve(12'h1F5, 3'd7, 5, 0);
    snoopCheck(12'h1F5, 0, "R9 squash on install edge");
    loadExpect(12'h1F6, 0, 3'd0, 1, "R9 install-edge squash misses");

    // illegal collision and mixed resolutions
    loadExpect(12'h078, 1, 3'd2, 1, "R3 spec miss");
    pulse(1, 3'd2, 1, 3'd2, 1, "R10 collision raises error");
    @(negedge clk);
    check("R10 error is one cycle", 32'(specErr), 32'd0);
    snoopCheck(12'h078, 0, "R10 squash won");
    pulse(1, 3'd2, 0, 3'd0, 0, "R10 commit no error");
    snoopCheck(12'h078, 0, "R10 line not revived");
    loadExpect(12'h2A0, 1, 3'd5, 1, "R3 spec miss");
    loadExpect(12'h33C, 1, 3'd6, 1, "R3 spec miss");
    pulse(1, 3'd5, 1, 3'd6, 0, "R10 different IDs no error");
    snoopCheck(12'h2A1, 1, "R10 commit applied");
    snoopCheck(12'h33C, 0, "R10 squash applied");
    loadExpect(12'h33D, 0, 3'd0, 1, "R10 squashed line misses");

    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule